// File: doc/BRIEF.md
# Hardware Stack Pointer Unit

This block holds the stack pointer of a small 8-bit processor core and drives the stack address onto the memory bus. The address is 13 bits wide. Only its low six bits are stored, and the upper seven bits are wired to the constant pattern 0000011. The pointer therefore always lies between 0x00C0 and 0x00FF, and it always names the next free stack byte. No overflow is reported. Pushing past the 64-byte window wraps the pointer around, and the new data lands on top of older entries.

The instruction sequencer issues five kinds of request:
- a single push;
- a single pull;
- a reset-stack command;
- a two-byte subroutine frame;
- a five-byte interrupt frame.

For a push, the byte is written at the current address and the pointer then steps down. For a pull, the pointer first steps up and the byte is read at the new address. A small internal sequencer walks the pointer across a whole frame, one byte per cycle. Every rollover of the six stored bits, in either direction, raises a one-cycle wrap pulse.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `stackAddr` is 0x00FF and `wrapPulse`, `memRead` and `frameBusy` are 0.
- R2: `stackAddr[12:6]` is always 7'b0000011, so every address lies in 0x00C0..0x00FF.
- R3: A push step drives `memWrite` high during that cycle, with `stackAddr` still showing the current address. After the next clock edge, `stackAddr` is one lower.
- R4: A pull step raises `stackAddr` by one at the next clock edge. `memRead` is high for exactly the one cycle in which the raised address is shown.
- R5: `rspReq` sets `stackAddr` to 0x00FF at the next edge. It has priority over every other request and cancels any frame in progress, after which `frameBusy` is 0.
- R6: A push step taken at 0x00C0 moves the pointer to 0x00FF. `wrapPulse` is high for the one cycle in which 0x00FF is shown.
- R7: A pull step taken at 0x00FF moves the pointer to 0x00C0. `wrapPulse` is high for the one cycle in which 0x00C0 is shown.
- R8: Outside a frame, and with no frame or reset-stack request, `pushReq` and `pullReq` asserted together are rejected: `memWrite` stays 0 and the address is unchanged.
- R9: An idle `frameReq` with `frameIrq`=0 takes two steps on consecutive cycles. The first step is in the request cycle. The direction is push when `framePull`=0 and pull when it is 1. `frameBusy` is high during the second step.
- R10: An idle `frameReq` with `frameIrq`=1 takes five steps on consecutive cycles. `frameBusy` is high during steps two to five.
- R11: While `frameBusy` is high, `pushReq`, `pullReq` and `frameReq` have no effect. When the unit is idle, `frameReq` takes precedence over single push and pull requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pushReq | input | 1 | Single push request |
| pullReq | input | 1 | Single pull request |
| rspReq | input | 1 | Reset-stack command |
| frameReq | input | 1 | Start a multi-byte frame |
| frameIrq | input | 1 | Frame kind: 0 = two-byte subroutine, 1 = five-byte interrupt |
| framePull | input | 1 | Frame direction: 0 = push, 1 = pull |
| stackAddr | output | 13 | Current stack address |
| memWrite | output | 1 | Write strobe for the byte at `stackAddr` (push step) |
| memRead | output | 1 | Read strobe for the byte at `stackAddr` (after a pull step) |
| wrapPulse | output | 1 | One-cycle pulse on rollover of the low six bits |
| frameBusy | output | 1 | A frame has steps still to take |

## Verification
The assertions check the following on every cycle:
- the strobes from control to datapath are mutually exclusive;
- each strobe moves the pointer by exactly one, or reloads it;
- the pointer holds when no strobe is given;
- a wrap pulse appears only with a matching rollover;
- a busy frame keeps stepping, and a conflicting request produces no strobe.

Only the bench scenarios can show the end-to-end effects:
- a frame takes exactly two or five steps in the chosen direction;
- a full 64-push walk lands back at 0x00FF;
- requests made during a frame leave no trace;
- a reset-stack command issued mid-frame both reloads the pointer and cancels the rest of the frame.

// File: rtl/stack_pkg.sv
package stack_pkg;
  // Strobes sent from the request control to the pointer datapath
  typedef struct packed {
    logic load;   // reload pointer to top of window
    logic dec;    // push step
    logic inc;    // pull step
  } spStrobe_t;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import stack_pkg::*;
#(
  parameter int SUB_LEN = 2,
  parameter int INT_LEN = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pushReq,
  input  logic      pullReq,
  input  logic      rspReq,
  input  logic      frameReq,
  input  logic      frameIrq,
  input  logic      framePull,
  output spStrobe_t strobe,
  output logic      frameBusy
);
  localparam int MAX_LEN = (INT_LEN > SUB_LEN) ? INT_LEN : SUB_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] SUB_LEFT = CNT_W'(SUB_LEN - 1);
  localparam logic [CNT_W-1:0] INT_LEFT = CNT_W'(INT_LEN - 1);

  logic [CNT_W-1:0] remain, nextRemain;
  logic             dirPull, nextDir;

  always_comb begin
    strobe     = '0;
    nextRemain = remain;
    nextDir    = dirPull;
    if (rspReq) begin
      strobe.load = 1'b1;
      nextRemain  = '0;
    end else if (remain != '0) begin
      strobe.inc = dirPull;
      strobe.dec = !dirPull;
      nextRemain = remain - 1'b1;
    end else if (frameReq) begin
      strobe.inc = framePull;
      strobe.dec = !framePull;
      nextRemain = frameIrq ? INT_LEFT : SUB_LEFT;
      nextDir    = framePull;
    end else if (pushReq && !pullReq) begin
      strobe.dec = 1'b1;
    end else if (pullReq && !pushReq) begin
      strobe.inc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain  <= '0;
      dirPull <= 1'b0;
    end else begin
      remain  <= nextRemain;
      dirPull <= nextDir;
    end
  end

  assign frameBusy = (remain != '0);

  // R8
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.dec, strobe.inc}));

  // R8
  conflict_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rspReq && !frameBusy && !frameReq && pushReq && pullReq) |-> (strobe == '0));

  // R10
  busy_steps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameBusy && !rspReq) |-> (strobe.inc || strobe.dec));

  // R5
  rsp_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspReq |=> !frameBusy);
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import stack_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LOW_W  = 6,
  parameter logic [ADDR_W-LOW_W-1:0] HI_PAT = 7'b0000011
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobe_t         strobe,
  output logic [ADDR_W-1:0] stackAddr,
  output logic              memWrite,
  output logic              memRead,
  output logic              wrapPulse
);
  localparam logic [LOW_W-1:0] TOP = {LOW_W{1'b1}};
  localparam logic [LOW_W-1:0] BOT = '0;

  logic [LOW_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= TOP;
      wrapPulse <= 1'b0;
      memRead   <= 1'b0;
    end else begin
      wrapPulse <= 1'b0;
      memRead   <= 1'b0;
      if (strobe.load) begin
        ptr <= TOP;
      end else if (strobe.dec) begin
        ptr       <= ptr - 1'b1;
        wrapPulse <= (ptr == BOT);
      end else if (strobe.inc) begin
        ptr       <= ptr + 1'b1;
        wrapPulse <= (ptr == TOP);
        memRead   <= 1'b1;
      end
    end
  end

  assign stackAddr = {HI_PAT, ptr};
  assign memWrite  = strobe.dec;

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |=> (ptr == $past(ptr) - 1'b1));

  // R4
  pull_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc |=> (ptr == $past(ptr) + 1'b1) && memRead);

  // R5
  rsp_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (stackAddr == {HI_PAT, TOP}));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(ptr) && !wrapPulse);

  // R6
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && ptr == BOT) |=> wrapPulse && ptr == TOP);

  // R7
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && ptr == TOP) |=> wrapPulse && ptr == BOT);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import stack_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int LOW_W   = 6,
  parameter int SUB_LEN = 2,
  parameter int INT_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              pullReq,
  input  logic              rspReq,
  input  logic              frameReq,
  input  logic              frameIrq,
  input  logic              framePull,
  output logic [ADDR_W-1:0] stackAddr,
  output logic              memWrite,
  output logic              memRead,
  output logic              wrapPulse,
  output logic              frameBusy
);
  spStrobe_t strobe;

  sp_ctrl #(.SUB_LEN(SUB_LEN), .INT_LEN(INT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .pullReq(pullReq),
    .rspReq(rspReq), .frameReq(frameReq), .frameIrq(frameIrq),
    .framePull(framePull), .strobe(strobe), .frameBusy(frameBusy)
  );

  sp_datapath #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stackAddr(stackAddr),
    .memWrite(memWrite), .memRead(memRead), .wrapPulse(wrapPulse)
  );
endmodule

// File: tb/stack_ptr_unit_tb.sv
module stack_ptr_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 0, pullReq = 0, rspReq = 0, frameReq = 0, frameIrq = 0, framePull = 0;
  logic [12:0] stackAddr;
  logic memWrite, memRead, wrapPulse, frameBusy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stack_ptr_unit u_dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .pullReq(pullReq),
    .rspReq(rspReq), .frameReq(frameReq), .frameIrq(frameIrq),
    .framePull(framePull), .stackAddr(stackAddr), .memWrite(memWrite),
    .memRead(memRead), .wrapPulse(wrapPulse), .frameBusy(frameBusy)
  );

  // expected item: {addr[12:0], wrap, rd, busy}
  logic [15:0] expQ[$];
  string       tagQ[$];

  // requirement model
  logic [5:0] mPtr = 6'h3F;
  int         mRemain = 0;
  bit         mDirPull = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pop and compare after every rising edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check({stackAddr, wrapPulse, memRead, frameBusy} == e, t,
            {stackAddr, wrapPulse, memRead, frameBusy}, e);
      // R2 fixed upper bits
      check(stackAddr[12:6] == 7'b0000011, "R2", {3'b0, stackAddr}, 16'h00C0);
    end
  end

  // driver: one cycle of stimulus, model update, expected item queued
  task automatic cyc(input bit pu, input bit pl, input bit rs, input bit fr,
                     input bit fk, input bit fp, input string tag);
    bit doDec, doInc, wrap, rd;
    @(negedge clk);
    pushReq = pu; pullReq = pl; rspReq = rs; frameReq = fr; frameIrq = fk; framePull = fp;
    doDec = 0; doInc = 0; wrap = 0; rd = 0;
    if (rs) begin
      mPtr = 6'h3F; mRemain = 0;
    end else if (mRemain != 0) begin
      doInc = mDirPull; doDec = !mDirPull; mRemain--;
    end else if (fr) begin
      doInc = fp; doDec = !fp; mDirPull = fp; mRemain = (fk ? 5 : 2) - 1;
    end else if (pu ^ pl) begin
      doInc = pl; doDec = pu;
    end
    if (doDec) begin wrap = (mPtr == 6'h00); mPtr = mPtr - 1'b1; end
    if (doInc) begin wrap = (mPtr == 6'h3F); mPtr = mPtr + 1'b1; rd = 1; end
    #1;
    check(memWrite == doDec, {tag, " memWrite"}, {15'b0, memWrite}, {15'b0, doDec});
    expQ.push_back({7'b0000011, mPtr, wrap, rd, (mRemain != 0)});
    tagQ.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog: actual=timeout expected=completion");
    errors++; checks++;
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({stackAddr, wrapPulse, memRead, frameBusy} == {13'h00FF, 3'b000}, "R1 in reset",
          {stackAddr, wrapPulse, memRead, frameBusy}, {13'h00FF, 3'b000});
    @(negedge clk); rstN = 1'b1;
    idle("R1 after reset");
    // single push and pull
    cyc(1, 0, 0, 0, 0, 0, "R3 push");
    cyc(1, 0, 0, 0, 0, 0, "R3 push");
    cyc(0, 1, 0, 0, 0, 0, "R4 pull");
    idle("R4 read ends");
    // conflict
    cyc(1, 1, 0, 0, 0, 0, "R8 conflict");
    idle("R8 after conflict");
    // reset-stack has priority
    cyc(1, 0, 1, 1, 0, 0, "R5 rsp priority");
    // walk full window down: 64 pushes, last wraps
    for (int i = 0; i < 63; i++) cyc(1, 0, 0, 0, 0, 0, "R3 walk");
    cyc(1, 0, 0, 0, 0, 0, "R6 wrap down");
    idle("R6 pulse ends");
    // pull at top wraps up
    cyc(0, 1, 0, 0, 0, 0, "R7 wrap up");
    cyc(1, 0, 0, 0, 0, 0, "R6 back down");
    cyc(0, 1, 0, 0, 0, 0, "R7 wrap up again");
    idle("R7 idle");
    // subroutine frame push, with push request alongside (frame wins)
    cyc(1, 0, 0, 1, 0, 0, "R9 sub frame step1");
    cyc(0, 1, 0, 1, 1, 1, "R11 ignored during busy");
    idle("R9 after sub frame");
    // interrupt frame pull
    cyc(0, 0, 0, 1, 1, 1, "R10 irq pull step1");
    cyc(1, 0, 0, 0, 0, 0, "R11 push ignored");
    cyc(0, 0, 0, 1, 0, 0, "R11 frame ignored");
    cyc(1, 1, 0, 0, 0, 0, "R10 irq step4");
    idle("R10 irq step5");
    idle("R10 done");
    // interrupt frame push, canceled mid-way
    cyc(0, 0, 0, 1, 1, 0, "R10 irq push step1");
    idle("R10 irq push step2");
    cyc(0, 0, 1, 0, 0, 0, "R5 rsp cancels frame");
    idle("R5 stays idle");
    cyc(0, 0, 0, 1, 0, 1, "R9 sub pull step1");
    idle("R9 sub pull step2");
    idle("R9 done");
    @(posedge clk); #2;
    done = 1;
    finishRun();
  end
endmodule